// File: doc/BRIEF.md
# Flash Read-Cache Control Register Block

This block is the software-visible control point for a read cache sitting in front of a serial flash. It sits on a simple request/ready register bus and holds three configuration bits (cache enable, cache power-down, and the error policy for writes to non-allocating cache windows). It also provides a self-clearing flush trigger, a status word and two saturating event counters. The cache datapath itself is outside the block. It reports hits and accesses as single-cycle pulses, and it reports attempted scratchpad accesses and bad-window writes as pulses that the block turns into a bus fault.

A flush walks the tag store one line per clock and presents a clear strobe with the line index, so the valid bits are dropped while the data array keeps its contents. A flush starts by itself when reset is applied, and a bus write can also start one. A read of the flush register is held off, with ready low, until the walk is over. Software can therefore either block on that read or poll the status word.

Top module: `cache_ctl_regs`

## Requirements
- R1: After reset, the control word (word offset 0x0) reads 0x3: enable in bit 0 is 1, error policy in bit 1 is 1, power-down in bit 3 is 0, and all other bits are 0. The cache_en output is 1, cache_pd is 0, and both counters read 0.
- R2: A control write stores bit 1 as the error policy and bit 3 as power-down, and stores enable as bit 0 AND NOT bit 3. While power-down is set, enable therefore reads 0 and cache_en stays low.
- R3: A write with bit 0 set to the flush word (offset 0x4) starts a walk that raises tag_clr for LINES consecutive cycles, with tag_clr_idx going 0, 1, ..., LINES-1. The flush word always reads 0.
- R4: A read of offset 0x4 while a walk is running keeps bus_ready low until the walk ends, and then completes with data 0.
- R5: Bit 0 of the status word (offset 0x8) reads 0 while a walk runs and 1 otherwise. Reset starts a full walk from line 0 without any bus action.
- R6: The hit counter (offset 0xC) adds 1 for each cycle hit_pulse is high, and the access counter (offset 0x10) does the same for acc_pulse. Each counter stops at all-ones of COUNT_W bits (0xFFFFFFFF at the default width).
- R7: A write of any value to a counter's offset sets that counter to 0, and this takes priority over an increment pulse in the same cycle.
- R8: bus_fault is high in any cycle where sram_acc is high while enable or power-down is set.
- R9: bus_fault is high in any cycle where alias_wr is high while the error policy bit is 1. When the policy bit is 0, alias_wr alone leaves bus_fault low.
- R10: Reads of unmapped offsets (0x14 to 0x1C) return 0 with no stall, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset, low two bits ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid when bus_ready is high |
| bus_ready | output | 1 | Access completes on this clock edge |
| hit_pulse | input | 1 | One cache hit this cycle |
| acc_pulse | input | 1 | One cache access this cycle |
| sram_acc | input | 1 | Scratchpad access attempted this cycle |
| alias_wr | input | 1 | Write to a non-allocating cache window this cycle |
| bus_fault | output | 1 | Error response for the flagged access |
| cache_en | output | 1 | Cache lookup enabled |
| cache_pd | output | 1 | Cache memories powered down |
| tag_clr | output | 1 | Clear the valid bit of line tag_clr_idx |
| tag_clr_idx | output | IDX_W | Line being cleared |

## Verification
The main collision is a counter-clearing write that lands on the same clock edge as an increment pulse for that counter. The bench drives hit_pulse high in the same cycle as a write to offset 0xC, and then checks that the counter reads exactly 0 rather than 1. The bench also reads the flush word while a walk is running. It judges that read by counting the stalled cycles and by comparing the strobed line indices against the expected sequence.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   // word indices of the mapped registers (byte offset / 4)
   localparam int WIDX_CTRL  = 0;
   localparam int WIDX_FLUSH = 1;
   localparam int WIDX_STAT  = 2;
   localparam int WIDX_HIT   = 3;
   localparam int WIDX_ACC   = 4;

   // bit positions inside the control word
   localparam int CB_EN   = 0;
   localparam int CB_BERR = 1;
   localparam int CB_PD   = 3;

   localparam int N_CTR = 2;
   localparam int CTR_HIT = 0;
   localparam int CTR_ACC = 1;

   typedef enum logic [2:0] {
      SEL_CTRL,
      SEL_FLUSH,
      SEL_STAT,
      SEL_HIT,
      SEL_ACC,
      SEL_NONE
   } sel_e;

   typedef struct packed {
      logic pd;
      logic berr;
      logic en;
   } ctrl_t;

endpackage

// File: rtl/ccr_bus_decode.sv
module ccr_bus_decode
   import ccr_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              flush_busy,
   output sel_e              sel,
   output logic              ready,
   output logic              wr_fire
);

   localparam int WW = ADDR_W - 2;

   logic [WW-1:0] word;
   logic          stall;

   assign word = bus_addr[ADDR_W-1:2];

   always_comb begin
      if      (word == WW'(WIDX_CTRL))  sel = SEL_CTRL;
      else if (word == WW'(WIDX_FLUSH)) sel = SEL_FLUSH;
      else if (word == WW'(WIDX_STAT))  sel = SEL_STAT;
      else if (word == WW'(WIDX_HIT))   sel = SEL_HIT;
      else if (word == WW'(WIDX_ACC))   sel = SEL_ACC;
      else                              sel = SEL_NONE;
   end

   // only a read of the flush word waits for the walk
   assign stall   = (sel == SEL_FLUSH) && !bus_we && flush_busy;
   assign ready   = bus_req && !stall;
   assign wr_fire = bus_req && bus_we && ready;

endmodule

// File: rtl/ccr_flush_seq.sv
module ccr_flush_seq #(
   parameter int LINES = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output logic             busy,
   output logic [IDX_W-1:0] clr_idx
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

   logic             busy_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
      end else if (busy_q) begin
         if (idx_q == LAST) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   assign busy    = busy_q;
   assign clr_idx = idx_q;

endmodule

// File: rtl/ccr_sat_ctr.sv
module ccr_sat_ctr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                        cnt_q <= '0;
      else if (clr)                   cnt_q <= '0;
      else if (inc && cnt_q != TOP)   cnt_q <= cnt_q + W'(1);
   end

   assign count = cnt_q;

endmodule

// File: rtl/cache_ctl_regs.sv
module cache_ctl_regs
   import ccr_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   parameter int COUNT_W = 32,
   parameter int LINES   = 8,
   localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ready,
   input  logic              hit_pulse,
   input  logic              acc_pulse,
   input  logic              sram_acc,
   input  logic              alias_wr,
   output logic              bus_fault,
   output logic              cache_en,
   output logic              cache_pd,
   output logic              tag_clr,
   output logic [IDX_W-1:0]  tag_clr_idx
);

   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must cover offset 0x10");
   end
   if (DATA_W < 4) begin : g_bad_data
      $error("DATA_W must hold the control word");
   end
   if (COUNT_W < 2 || COUNT_W > DATA_W) begin : g_bad_cnt
      $error("COUNT_W must lie in 2..DATA_W");
   end
   if (LINES < 2) begin : g_bad_lines
      $error("LINES must be at least 2");
   end

   sel_e         sel;
   logic         wr_fire;
   logic         flush_busy;
   logic         flush_go;
   ctrl_t        ctrl_q;
   logic [N_CTR-1:0] ctr_clr;
   logic [N_CTR-1:0] ctr_inc;
   logic [COUNT_W-1:0] ctr_val [N_CTR];
   logic [COUNT_W-1:0] hit_cnt;
   logic [COUNT_W-1:0] acc_cnt;
   logic         hit_clr;

   ccr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_req    (bus_req),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .flush_busy (flush_busy),
      .sel        (sel),
      .ready      (bus_ready),
      .wr_fire    (wr_fire)
   );

   // control word: power-down overrides enable in the same write
   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q.pd   <= 1'b0;
         ctrl_q.berr <= 1'b1;
         ctrl_q.en   <= 1'b1;
      end else if (wr_fire && sel == SEL_CTRL) begin
         ctrl_q.pd   <= bus_wdata[CB_PD];
         ctrl_q.berr <= bus_wdata[CB_BERR];
         ctrl_q.en   <= bus_wdata[CB_EN] & ~bus_wdata[CB_PD];
      end
   end

   assign flush_go = wr_fire && (sel == SEL_FLUSH) && bus_wdata[0];

   ccr_flush_seq #(.LINES(LINES), .IDX_W(IDX_W)) u_flush (
      .clk     (clk),
      .rst     (rst),
      .start   (flush_go),
      .busy    (flush_busy),
      .clr_idx (tag_clr_idx)
   );

   assign ctr_inc[CTR_HIT] = hit_pulse;
   assign ctr_inc[CTR_ACC] = acc_pulse;
   assign ctr_clr[CTR_HIT] = wr_fire && (sel == SEL_HIT);
   assign ctr_clr[CTR_ACC] = wr_fire && (sel == SEL_ACC);

   for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
      ccr_sat_ctr #(.W(COUNT_W)) u_ctr (
         .clk   (clk),
         .rst   (rst),
         .clr   (ctr_clr[i]),
         .inc   (ctr_inc[i]),
         .count (ctr_val[i])
      );
   end

   assign hit_cnt = ctr_val[CTR_HIT];
   assign acc_cnt = ctr_val[CTR_ACC];
   assign hit_clr = ctr_clr[CTR_HIT];

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_CTRL: begin
            bus_rdata[CB_EN]   = ctrl_q.en;
            bus_rdata[CB_BERR] = ctrl_q.berr;
            bus_rdata[CB_PD]   = ctrl_q.pd;
         end
         SEL_STAT:  bus_rdata[0] = ~flush_busy;
         SEL_HIT:   bus_rdata = DATA_W'(hit_cnt);
         SEL_ACC:   bus_rdata = DATA_W'(acc_cnt);
         default:   bus_rdata = '0;
      endcase
   end

   assign bus_fault = (sram_acc & (ctrl_q.en | ctrl_q.pd)) |
                      (alias_wr & ctrl_q.berr);
   assign cache_en  = ctrl_q.en;
   assign cache_pd  = ctrl_q.pd;
   assign tag_clr   = flush_busy;

endmodule

// File: rtl/cache_ctl_regs_chk.sv
module cache_ctl_regs_chk #(
   parameter int ADDR_W  = 5,
   parameter int COUNT_W = 32,
   parameter int IDX_W   = 3
) (
   input logic               clk,
   input logic               rst,
   input logic               bus_req,
   input logic               bus_we,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_ready,
   input logic               cache_en,
   input logic               cache_pd,
   input logic               tag_clr,
   input logic [IDX_W-1:0]   tag_clr_idx,
   input logic               sram_acc,
   input logic               bus_fault,
   input logic [COUNT_W-1:0] hit_cnt,
   input logic               hit_clr
);

   localparam logic [COUNT_W-1:0] TOP = {COUNT_W{1'b1}};

   AST_PD_KILLS_EN: assert property (@(posedge clk) disable iff (rst)
      cache_pd |-> !cache_en);  // R2

   AST_FLUSH_STEP: assert property (@(posedge clk) disable iff (rst)
      (tag_clr && $past(tag_clr) && tag_clr_idx != '0)
         |-> tag_clr_idx == $past(tag_clr_idx) + IDX_W'(1));  // R3

   AST_FLUSH_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (bus_req && !bus_we && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1) && tag_clr)
         |-> !bus_ready);  // R4

   AST_HIT_SATURATE: assert property (@(posedge clk) disable iff (rst)
      (hit_cnt == TOP && !hit_clr) |=> hit_cnt == TOP);  // R6

   AST_HIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
      hit_clr |=> hit_cnt == '0);  // R7

   AST_SRAM_FAULT: assert property (@(posedge clk) disable iff (rst)
      (sram_acc && (cache_en || cache_pd)) |-> bus_fault);  // R8

endmodule

bind cache_ctl_regs cache_ctl_regs_chk #(
   .ADDR_W  (ADDR_W),
   .COUNT_W (COUNT_W),
   .IDX_W   (IDX_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .bus_req     (bus_req),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .bus_ready   (bus_ready),
   .cache_en    (cache_en),
   .cache_pd    (cache_pd),
   .tag_clr     (tag_clr),
   .tag_clr_idx (tag_clr_idx),
   .sram_acc    (sram_acc),
   .bus_fault   (bus_fault),
   .hit_cnt     (hit_cnt),
   .hit_clr     (hit_clr)
);

// File: tb/cache_ctl_regs_test.sv
module cache_ctl_regs_test;

   localparam int ADDR_W  = 5;
   localparam int DATA_W  = 32;
   localparam int COUNT_W = 8;
   localparam int LINES   = 8;
   localparam int IDX_W   = 3;
   localparam int CMAX    = (1 << COUNT_W) - 1;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              bus_req = 1'b0;
   logic              bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              bus_ready;
   logic              hit_pulse = 1'b0;
   logic              acc_pulse = 1'b0;
   logic              sram_acc = 1'b0;
   logic              alias_wr = 1'b0;
   logic              bus_fault;
   logic              cache_en;
   logic              cache_pd;
   logic              tag_clr;
   logic [IDX_W-1:0]  tag_clr_idx;

   int checks = 0;
   int errors = 0;
   int strobes = 0;
   int seq_bad = 0;
   bit done = 1'b0;

   // model state
   bit m_en = 1'b1, m_berr = 1'b1, m_pd = 1'b0;
   int m_hit = 0, m_acc = 0;

   always #4 clk = ~clk;

   cache_ctl_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W), .LINES(LINES)
   ) uut (
      .clk(clk), .rst(rst),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .hit_pulse(hit_pulse), .acc_pulse(acc_pulse),
      .sram_acc(sram_acc), .alias_wr(alias_wr), .bus_fault(bus_fault),
      .cache_en(cache_en), .cache_pd(cache_pd),
      .tag_clr(tag_clr), .tag_clr_idx(tag_clr_idx)
   );

   // strobe monitor: each strobe should carry the next line index
   always @(negedge clk) begin
      if (!rst && tag_clr) begin
         if (int'(tag_clr_idx) != (strobes % LINES)) seq_bad++;
         strobes++;
      end
   end

   function automatic logic [31:0] exp_ctrl(bit en, bit berr, bit pd);
      return {28'd0, pd, 1'b0, berr, en};
   endfunction

   function automatic bit exp_fault(bit s, bit a, bit en, bit berr, bit pd);
      return (s && (en || pd)) || (a && berr);
   endfunction

   function automatic int sat_inc(int v);
      return (v >= CMAX) ? CMAX : v + 1;
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus(input bit we, input logic [ADDR_W-1:0] addr,
                      input logic [31:0] wd, input bit with_hit,
                      output logic [31:0] rd, output int stall);
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
      hit_pulse = with_hit;
      #1;
      stall = 0;
      while (!bus_ready) begin
         @(negedge clk);
         #1;
         stall++;
      end
      rd = bus_rdata;
      @(posedge clk);
      #1;
      bus_req = 1'b0; bus_we = 1'b0; hit_pulse = 1'b0;
   endtask

   task automatic ctrl_write(logic [31:0] wd);
      logic [31:0] rd; int st;
      bus(1'b1, 5'h00, wd, 1'b0, rd, st);
      m_pd = wd[3]; m_berr = wd[1]; m_en = wd[0] & ~wd[3];
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] rd;
      int st;
      void'($urandom(32'd1234));

      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R5: walk from reset is running, status reads 0
      bus(1'b0, 5'h08, 32'd0, 1'b0, rd, st);
      chk(rd == 32'd0 && st == 0, "R5 status during reset walk", rd, 0);
      // R1 reset values
      bus(1'b0, 5'h00, 32'd0, 1'b0, rd, st);
      chk(rd == 32'h3, "R1 control reset", rd, 3);
      chk(cache_en == 1'b1 && cache_pd == 1'b0, "R1 outputs reset",
          {cache_en, cache_pd}, 2'b10);
      // R4 blocking read of flush word
      bus(1'b0, 5'h04, 32'd0, 1'b0, rd, st);
      chk(st > 0 && rd == 32'd0, "R4 flush read stalls", st, 1);
      chk(strobes == LINES && seq_bad == 0, "R5 reset walk lines", strobes, LINES);
      bus(1'b0, 5'h08, 32'd0, 1'b0, rd, st);
      chk(rd == 32'd1, "R5 status idle", rd, 1);
      bus(1'b0, 5'h0C, 32'd0, 1'b0, rd, st);
      chk(rd == 32'd0, "R1 hit counter reset", rd, 0);
      bus(1'b0, 5'h10, 32'd0, 1'b0, rd, st);
      chk(rd == 32'd0, "R1 access counter reset", rd, 0);

      // R3 software flush
      strobes = 0; seq_bad = 0;
      bus(1'b1, 5'h04, 32'h1, 1'b0, rd, st);
      bus(1'b0, 5'h08, 32'd0, 1'b0, rd, st);
      chk(rd == 32'd0, "R5 status while flushing", rd, 0);
      bus(1'b0, 5'h04, 32'd0, 1'b0, rd, st);
      chk(rd == 32'd0 && st > 0, "R4 flush read after start", st, 1);
      chk(strobes == LINES && seq_bad == 0, "R3 walk covers all lines",
          strobes, LINES);
      // R3 write with bit 0 clear does not start a walk
      strobes = 0;
      bus(1'b1, 5'h04, 32'hFFFF_FFFE, 1'b0, rd, st);
      repeat (2) @(negedge clk);
      chk(strobes == 0, "R3 no walk without bit 0", strobes, 0);

      // R2 directed and random control writes
      ctrl_write(32'h9);
      bus(1'b0, 5'h00, 32'd0, 1'b0, rd, st);
      chk(rd == 32'h8 && !cache_en && cache_pd, "R2 power-down forces enable low",
          rd, 8);
      for (int i = 0; i < 20; i++) begin
         ctrl_write($urandom);
         bus(1'b0, 5'h00, 32'd0, 1'b0, rd, st);
         chk(rd == exp_ctrl(m_en, m_berr, m_pd) && cache_en == m_en &&
             cache_pd == m_pd, "R2 control readback", rd,
             exp_ctrl(m_en, m_berr, m_pd));
      end

      // R8 R9 fault response under random settings
      for (int i = 0; i < 40; i++) begin
         if (i % 5 == 0) ctrl_write($urandom);
         @(negedge clk);
         sram_acc = 1'($urandom); alias_wr = 1'($urandom);
         #1;
         chk(bus_fault == exp_fault(sram_acc, alias_wr, m_en, m_berr, m_pd),
             sram_acc ? "R8 scratchpad fault" : "R9 window write fault",
             bus_fault, exp_fault(sram_acc, alias_wr, m_en, m_berr, m_pd));
      end
      @(negedge clk);
      sram_acc = 1'b0; alias_wr = 1'b0;
      // R9 policy off: window write gives no fault
      ctrl_write(32'h1);
      @(negedge clk); alias_wr = 1'b1; #1;
      chk(bus_fault == 1'b0, "R9 policy clear no fault", bus_fault, 0);
      @(negedge clk); alias_wr = 1'b0;

      // R6 random pulses then saturation
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         hit_pulse = ($urandom % 10) < 3;
         acc_pulse = ($urandom % 2) == 1;
         if (hit_pulse) m_hit = sat_inc(m_hit);
         if (acc_pulse) m_acc = sat_inc(m_acc);
      end
      @(negedge clk); hit_pulse = 1'b0; acc_pulse = 1'b0;
      bus(1'b0, 5'h0C, 32'd0, 1'b0, rd, st);
      chk(rd == 32'(m_hit), "R6 hit count", rd, m_hit);
      bus(1'b0, 5'h10, 32'd0, 1'b0, rd, st);
      chk(rd == 32'(m_acc), "R6 access count", rd, m_acc);
      for (int i = 0; i < 300; i++) begin
         @(negedge clk); hit_pulse = 1'b1; acc_pulse = 1'b1;
      end
      @(negedge clk); hit_pulse = 1'b0; acc_pulse = 1'b0;
      bus(1'b0, 5'h0C, 32'd0, 1'b0, rd, st);
      chk(rd == 32'(CMAX), "R6 hit saturates", rd, CMAX);
      bus(1'b0, 5'h10, 32'd0, 1'b0, rd, st);
      chk(rd == 32'(CMAX), "R6 access saturates", rd, CMAX);

      // R7 clear beats a same-cycle hit
      bus(1'b1, 5'h0C, $urandom, 1'b1, rd, st);
      bus(1'b0, 5'h0C, 32'd0, 1'b0, rd, st);
      chk(rd == 32'd0, "R7 clear wins over hit", rd, 0);
      bus(1'b1, 5'h10, $urandom, 1'b0, rd, st);
      bus(1'b0, 5'h10, 32'd0, 1'b0, rd, st);
      chk(rd == 32'd0, "R7 access clear", rd, 0);

      // R10 unmapped offsets
      ctrl_write(32'h2);
      bus(1'b0, 5'h14, 32'd0, 1'b0, rd, st);
      chk(rd == 32'd0 && st == 0, "R10 unmapped read 0x14", rd, 0);
      bus(1'b0, 5'h1C, 32'd0, 1'b0, rd, st);
      chk(rd == 32'd0 && st == 0, "R10 unmapped read 0x1C", rd, 0);
      bus(1'b1, 5'h18, 32'hFFFF_FFFF, 1'b0, rd, st);
      bus(1'b0, 5'h00, 32'd0, 1'b0, rd, st);
      chk(rd == 32'h2, "R10 unmapped write ignored", rd, 2);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule